// File: doc/BRIEF.md
# Next-PC Candidate and Redirect Unit

This combinational unit sits in the execute stage of a 32-bit in-order pipeline. From the instruction's own PC, its sign-extended immediate, the ALU result and two control bits, it produces every candidate the fetch stage may need. These are the sequential successor, the PC-relative sum and the final redirect target. It also produces one bit that tells fetch to take that target.

The redirect decision has two sources. A register-indirect jump always redirects. A conditional branch redirects only when the branch control is active and the comparison result has its lowest bit set; no other bit of the ALU result takes part. For a register-indirect jump, the target is the ALU sum with its lowest bit cleared. Otherwise the target is the PC plus the branch immediate doubled. All sums wrap at 32 bits, and the unit holds no state.

Top module: `nxt_pc_unit`

## Requirements
- R1: `seq_pc_o` equals `pc_i + 4`, wrapped to 32 bits.
- R2: `rel_pc_o` equals `pc_i + imm_i`, wrapped to 32 bits.
- R3: `redirect_o` equals `ind_jump_i | (cond_br_i & alu_res_i[0])`.
- R4: When `ind_jump_i` is 1, `target_o` equals `alu_res_i` with bit 0 forced to 0, and bits 31..1 copied unchanged.
- R5: When `ind_jump_i` is 0, `target_o` equals `pc_i + (imm_i << 1)`, wrapped to 32 bits.
- R6: Bits 31..1 of `alu_res_i` have no effect on `redirect_o`.
- R7: A sum that crosses 2^32 wraps. For example, `pc_i = 32'hFFFF_FFFC` gives `seq_pc_o = 0`.
- R8: All outputs follow their inputs with no clock, so a changed input is visible in the same time step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | PC of the instruction in execute |
| imm_i | input | 32 | Sign-extended immediate |
| ind_jump_i | input | 1 | Register-indirect jump select |
| cond_br_i | input | 1 | Conditional branch control |
| alu_res_i | input | 32 | ALU result: jump sum or compare flag in bit 0 |
| seq_pc_o | output | 32 | Sequential successor PC |
| rel_pc_o | output | 32 | PC plus immediate |
| target_o | output | 32 | Redirect target |
| redirect_o | output | 1 | Fetch must take `target_o` |

## Verification
The decision is tried over all four combinations of the two control bits, with the compare flag both set and clear. This separates an OR from an AND and shows whether the flag gates only the branch path. Odd and even ALU results under an indirect jump show whether bit 0 is cleared while the upper bits pass through. ALU results with only upper bits set show that they are ignored. Negative immediates and PCs near the top of the address space expose sign and wrap errors. A doubled immediate against an undoubled one tells the branch target apart from the relative sum.

// File: rtl/nxt_pc_pkg.sv
package nxt_pc_pkg;

   typedef enum logic {
      ADD_FLAT  = 1'b0,
      ADD_SPLIT = 1'b1
   } add_style_e;

   localparam int unsigned DEF_XLEN = 32;

endpackage

// File: rtl/nxt_pc_adder.sv
module nxt_pc_adder #(
   parameter int unsigned            W     = 32,
   parameter nxt_pc_pkg::add_style_e STYLE = nxt_pc_pkg::ADD_FLAT
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] sum_o
);
   localparam int unsigned LO_W = W / 2;
   localparam int unsigned HI_W = W - LO_W;

   if (W < 2) begin : g_bad_width
      $error("nxt_pc_adder: W must be at least 2");
   end

   if (STYLE == nxt_pc_pkg::ADD_SPLIT) begin : g_split
      logic [LO_W:0]   lo_sum;
      logic [HI_W-1:0] hi_c0;
      logic [HI_W-1:0] hi_c1;

      always_comb begin
         lo_sum = {1'b0, a_i[LO_W-1:0]} + {1'b0, b_i[LO_W-1:0]};
         hi_c0  = a_i[W-1:LO_W] + b_i[W-1:LO_W];
         hi_c1  = hi_c0 + HI_W'(1);
         sum_o  = {(lo_sum[LO_W] ? hi_c1 : hi_c0), lo_sum[LO_W-1:0]};
      end
   end else begin : g_flat
      always_comb begin
         sum_o = a_i + b_i;
      end
   end

endmodule

// File: rtl/nxt_pc_tgt_sel.sv
module nxt_pc_tgt_sel #(
   parameter int unsigned W        = 32,
   parameter int unsigned CLR_BITS = 1
) (
   input  logic         ind_jump_i,
   input  logic [W-1:0] jump_sum_i,
   input  logic [W-1:0] br_tgt_i,
   output logic [W-1:0] target_o
);
   localparam logic [W-1:0] KEEP_MASK = ~((W'(1) << CLR_BITS) - W'(1));

   if (CLR_BITS >= W) begin : g_bad_clr
      $error("nxt_pc_tgt_sel: CLR_BITS must be below W");
   end

   always_comb begin
      target_o = ind_jump_i ? (jump_sum_i & KEEP_MASK) : br_tgt_i;
   end

   always_comb begin
      if (!$isunknown({ind_jump_i, jump_sum_i})) begin
         if (ind_jump_i) begin
            p_jump_aligned_r4: assert (target_o[0] == 1'b0 &&
                                       target_o[W-1:1] == jump_sum_i[W-1:1])
               else $error("R4: indirect jump target not aligned");
         end
      end
   end

endmodule

// File: rtl/nxt_pc_decide.sv
module nxt_pc_decide #(
   parameter int unsigned W        = 32,
   parameter int unsigned FLAG_BIT = 0
) (
   input  logic         ind_jump_i,
   input  logic         cond_br_i,
   input  logic [W-1:0] cmp_res_i,
   output logic         redirect_o
);
   if (FLAG_BIT >= W) begin : g_bad_flag
      $error("nxt_pc_decide: FLAG_BIT must be below W");
   end

   logic flag;

   always_comb begin
      flag       = cmp_res_i[FLAG_BIT];
      redirect_o = ind_jump_i | (cond_br_i & flag);
   end

endmodule

// File: rtl/nxt_pc_unit.sv
module nxt_pc_unit #(
   parameter int unsigned            XLEN      = nxt_pc_pkg::DEF_XLEN,
   parameter int unsigned            STEP      = 4,
   parameter int unsigned            BR_SHIFT  = 1,
   parameter int unsigned            JMP_CLR   = 1,
   parameter nxt_pc_pkg::add_style_e ADD_STYLE = nxt_pc_pkg::ADD_SPLIT
) (
   input  logic [XLEN-1:0] pc_i,
   input  logic [XLEN-1:0] imm_i,
   input  logic            ind_jump_i,
   input  logic            cond_br_i,
   input  logic [XLEN-1:0] alu_res_i,
   output logic [XLEN-1:0] seq_pc_o,
   output logic [XLEN-1:0] rel_pc_o,
   output logic [XLEN-1:0] target_o,
   output logic            redirect_o
);
   localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

   if (XLEN < 8) begin : g_bad_xlen
      $error("nxt_pc_unit: XLEN must be at least 8");
   end
   if (BR_SHIFT >= XLEN) begin : g_bad_shift
      $error("nxt_pc_unit: BR_SHIFT must be below XLEN");
   end

   logic [XLEN-1:0] imm_scaled;
   logic [XLEN-1:0] br_tgt;

   assign imm_scaled = imm_i << BR_SHIFT;

   nxt_pc_adder #(.W(XLEN), .STYLE(ADD_STYLE)) u_seq (
      .a_i   (pc_i),
      .b_i   (STEP_V),
      .sum_o (seq_pc_o)
   );

   nxt_pc_adder #(.W(XLEN), .STYLE(ADD_STYLE)) u_rel (
      .a_i   (pc_i),
      .b_i   (imm_i),
      .sum_o (rel_pc_o)
   );

   nxt_pc_adder #(.W(XLEN), .STYLE(ADD_STYLE)) u_br (
      .a_i   (pc_i),
      .b_i   (imm_scaled),
      .sum_o (br_tgt)
   );

   nxt_pc_tgt_sel #(.W(XLEN), .CLR_BITS(JMP_CLR)) u_sel (
      .ind_jump_i (ind_jump_i),
      .jump_sum_i (alu_res_i),
      .br_tgt_i   (br_tgt),
      .target_o   (target_o)
   );

   nxt_pc_decide #(.W(XLEN), .FLAG_BIT(0)) u_dec (
      .ind_jump_i (ind_jump_i),
      .cond_br_i  (cond_br_i),
      .cmp_res_i  (alu_res_i),
      .redirect_o (redirect_o)
   );

   always_comb begin
      if (!$isunknown({pc_i, imm_i, ind_jump_i, cond_br_i, alu_res_i})) begin
         p_seq_step_r1: assert (XLEN'(seq_pc_o - pc_i) == STEP_V)
            else $error("R1: sequential successor wrong");
         p_rel_sum_r2: assert (XLEN'(rel_pc_o - imm_i) == pc_i)
            else $error("R2: relative sum wrong");
         if (ind_jump_i) begin
            p_jump_redirects_r3: assert (redirect_o)
               else $error("R3: indirect jump did not redirect");
         end
         if (!ind_jump_i && !cond_br_i) begin
            p_idle_no_redirect_r3: assert (!redirect_o)
               else $error("R3: redirect with no control active");
         end
         if (!ind_jump_i) begin
            p_branch_target_r5: assert (XLEN'(target_o - pc_i) == imm_scaled)
               else $error("R5: branch target wrong");
         end
      end
   end

endmodule

// File: tb/tb_nxt_pc_unit.sv
module tb_nxt_pc_unit;
   logic        clk = 1'b0;
   logic [31:0] pc_i = '0;
   logic [31:0] imm_i = '0;
   logic        ind_jump_i = 1'b0;
   logic        cond_br_i = 1'b0;
   logic [31:0] alu_res_i = '0;
   logic [31:0] seq_pc_o, rel_pc_o, target_o;
   logic        redirect_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   nxt_pc_unit dut (
      .pc_i       (pc_i),
      .imm_i      (imm_i),
      .ind_jump_i (ind_jump_i),
      .cond_br_i  (cond_br_i),
      .alu_res_i  (alu_res_i),
      .seq_pc_o   (seq_pc_o),
      .rel_pc_o   (rel_pc_o),
      .target_o   (target_o),
      .redirect_o (redirect_o)
   );

   task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [31:0] pc, input logic [31:0] imm, input logic j,
                        input logic b, input logic [31:0] alu);
      pc_i = pc; imm_i = imm; ind_jump_i = j; cond_br_i = b; alu_res_i = alu;
      #1;
   endtask

   task automatic check_all(input string tag);
      logic [31:0] e_tgt;
      e_tgt = ind_jump_i ? (alu_res_i & 32'hFFFF_FFFE) : (pc_i + (imm_i << 1));
      chk32({tag, " R1"}, seq_pc_o, pc_i + 32'd4);
      chk32({tag, " R2"}, rel_pc_o, pc_i + imm_i);
      chk32({tag, ind_jump_i ? " R4" : " R5"}, target_o, e_tgt);
      chk32({tag, " R3"}, {31'd0, redirect_o},
            {31'd0, ind_jump_i | (cond_br_i & alu_res_i[0])});
   endtask

   task automatic t_idle;
      @(negedge clk); drive('0, '0, 1'b0, 1'b0, '0);
      check_all("idle");
   endtask

   task automatic t_forward_branch;
      @(negedge clk); drive(32'h0000_1000, 32'h0000_0010, 1'b0, 1'b1, 32'h1);
      chk32("R5 fwd", target_o, 32'h0000_1020);
      chk32("R2 fwd", rel_pc_o, 32'h0000_1010);
      chk32("R3 fwd", {31'd0, redirect_o}, 32'd1);
   endtask

   task automatic t_backward_branch;
      @(negedge clk); drive(32'h0000_2000, 32'hFFFF_FFF8, 1'b0, 1'b1, 32'h0);
      chk32("R5 back", target_o, 32'h0000_1FF0);
      chk32("R2 back", rel_pc_o, 32'h0000_1FF8);
      chk32("R3 not taken", {31'd0, redirect_o}, 32'd0);
   endtask

   task automatic t_jump;
      @(negedge clk); drive(32'h0000_4000, 32'h0000_0100, 1'b1, 1'b0, 32'h8000_0123);
      chk32("R4 odd", target_o, 32'h8000_0122);
      chk32("R3 jump", {31'd0, redirect_o}, 32'd1);
      @(negedge clk); drive(32'h0000_4000, 32'h0000_0100, 1'b1, 1'b1, 32'h0000_0456);
      chk32("R4 even", target_o, 32'h0000_0456);
      chk32("R3 jump+br", {31'd0, redirect_o}, 32'd1);
   endtask

   task automatic t_upper_ignored;
      @(negedge clk); drive(32'h0000_0100, 32'h4, 1'b0, 1'b1, 32'hFFFF_FFFE);
      chk32("R6 upper set", {31'd0, redirect_o}, 32'd0);
      @(negedge clk); drive(32'h0000_0100, 32'h4, 1'b0, 1'b0, 32'hFFFF_FFFF);
      chk32("R3 flag no ctrl", {31'd0, redirect_o}, 32'd0);
   endtask

   task automatic t_wrap;
      @(negedge clk); drive(32'hFFFF_FFFC, 32'h0000_0008, 1'b0, 1'b0, '0);
      chk32("R7 seq", seq_pc_o, 32'h0000_0000);
      chk32("R7 rel", rel_pc_o, 32'h0000_0004);
      chk32("R7 br", target_o, 32'h0000_000C);
   endtask

   task automatic t_no_clock;
      pc_i = 32'h0000_0040;
      #1;
      chk32("R8 seq", seq_pc_o, 32'h0000_0044);
      cond_br_i = 1'b1; alu_res_i = 32'h1;
      #1;
      chk32("R8 redirect", {31'd0, redirect_o}, 32'd1);
   endtask

   task automatic t_sweep;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         drive(32'h1234_0000 + 32'(i * 36), 32'(i * 32'h0101_0101) ^ 32'hF0F0_0000,
               i[0], i[1], 32'(i * 32'h1111_1111) | {31'd0, i[2]});
         check_all("sweep");
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      t_idle();
      t_forward_branch();
      t_backward_branch();
      t_jump();
      t_upper_ignored();
      t_wrap();
      t_no_clock();
      t_sweep();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule